// File: doc/BRIEF.md
# Two-Wire Register Bank Slave with Auto-Increment Pointer

This block is a two-wire (I2C) target that lets a bus master read and write a small bank of byte registers. SCL and SDA are sampled on a fast system clock, run through synchronizers, and edge-detected. START, repeated START and STOP are recognised from those edges. A 7-bit address whose lowest bit comes from a strap pin selects the device. SDA is driven open-drain through a single pull-low enable.

After the address, the first byte of a write is a command byte. It loads a 3-bit register pointer and an auto-increment flag. Each byte that follows is written to the pointed register. To read, the master writes the command byte, issues a repeated START and then the read address. The bank is then shifted out from the pointed register.

Register 0 reflects a small read-only input port. Registers 1 to 5 drive the exported register bus. The block has no streaming data path at its edge, so every pin is a plain level or strobe-free signal with no back-pressure. The bank values are always visible on the register bus.

Top module: `i2c_regbank_slave`

## Requirements
- R1: During and after reset the bank holds register1=00h, register2=80h, register3=00h, register4=80h and register5=F0h. The pointer and the auto-increment flag are 0 and `sda_oe` is 0. A read issued without a command byte therefore starts at register 0.
- R2: An SDA fall while SCL is high (START) starts a new address phase from any state, including in the middle of a transfer. An SDA rise while SCL is high (STOP) returns the block to idle with SDA released.
- R3: The device address is 110000 followed by `addr_sel`, sent MSB first, with R/W as the eighth bit (1 = read). A matching address is acknowledged by pulling SDA low during the ninth clock. A non-matching address is not acknowledged, and the bus is then ignored until the next START.
- R4: The first byte after a write address is the command byte. Bits 2:0 load the pointer, bit 4 loads the auto-increment flag, and bits 7:5 and bit 3 are ignored. The command byte changes no bank register. Every byte received while addressed is acknowledged.
- R5: Register k (1 to 5) appears on `reg_out[8*k-1:8*(k-1)]`.
- R6: A data byte written while the pointer is 1 to 5 replaces the pointed register.
- R7: Register 0 reads as {000000, `port_in`}. A write to it is acknowledged and changes nothing.
- R8: At pointer values 6 and 7, writes are acknowledged with no effect and reads return 00h.
- R9: With auto-increment set, the pointer advances by one after every data byte read or written. From 5 or above it wraps to 0.
- R10: With auto-increment clear, the pointer stays fixed across successive data bytes.
- R11: Read data leaves MSB first, one bit per SCL pulse. A master ACK fetches the next byte. A master NACK ends the read and leaves SDA released.
- R12: `sda_oe` changes only while SCL is low.
- R13: A reset asserted in the middle of a transfer returns every register and the bus state machine to their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL level seen on the bus |
| sda_in | input | 1 | SDA level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 1 | Strap value for the lowest address bit |
| port_in | input | 2 | Pin levels returned by register 0 |
| reg_out | output | 40 | Registers 1 to 5, register k in byte k-1 |

## Verification
Two situations are hard to reach from the pins. One is the wrap of the pointer while a read is in flight: the read must start at a high or unimplemented pointer, which the master can only set with a write command byte, a repeated START and then a read. The other is a reset during a byte, which must be sequenced against the SCL phase. The stimulus sweeps every start pointer with auto-increment for both writes and reads of several bytes. It compares each byte with an arithmetic model of the pointer, drops reset halfway through a data byte, and then reads without a command byte.

// File: rtl/i2c_rb_pkg.sv
`timescale 1ns/1ps
package i2c_rb_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } link_state_e;

  // Default of bank entry idx: the last entry is the selector, odd entries
  // are prescalers, even entries are duty values.
  function automatic logic [BYTE_W-1:0] reset_value(input int idx, input int nregs);
    if (idx == nregs - 1) return 8'hF0;
    else if ((idx % 2) == 1) return 8'h00;
    else return 8'h80;
  endfunction

endpackage

// File: rtl/i2c_rb_sync.sv
`timescale 1ns/1ps
module i2c_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int W = STAGES + 1;

  logic [W-1:0] scl_p;
  logic [W-1:0] sda_p;
  logic         scl_d;
  logic         sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[W-2:0], scl_in};
      sda_p <= {sda_p[W-2:0], sda_in};
    end
  end

  assign scl_s = scl_p[W-2];
  assign sda_s = sda_p[W-2];
  assign scl_d = scl_p[W-1];
  assign sda_d = sda_p[W-1];

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_rb_link.sv
`timescale 1ns/1ps
module i2c_rb_link
  import i2c_rb_pkg::*;
#(
  parameter logic [5:0] ADDR_FIXED = 6'b110000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              addr_sel,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_stb,
  output logic              wr_is_cmd,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_stb,
  output logic              sda_oe
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  link_state_e       state_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              rw_q;
  logic              cmd_phase;
  logic              mack_q;
  logic              byte_in;

  assign byte_in   = (bit_cnt == FULL);
  assign wr_stb    = (state_q == ST_RX) && scl_fall && byte_in;
  assign wr_is_cmd = cmd_phase;
  assign wr_data   = rx_sh;
  assign rd_stb    = (state_q == ST_TX) && scl_fall && byte_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rw_q      <= 1'b0;
      cmd_phase <= 1'b0;
      mack_q    <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (start_det) begin
      state_q <= ST_ADDR;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      sda_oe  <= 1'b0;
    end else begin
      case (state_q)
        ST_ADDR: begin
          if (scl_rise && !byte_in) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && byte_in) begin
            if (rx_sh[BYTE_W-1:1] == {ADDR_FIXED, addr_sel}) begin
              sda_oe  <= 1'b1;
              rw_q    <= rx_sh[0];
              state_q <= ST_ADDR_ACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw_q) begin
              tx_sh   <= rd_data;
              sda_oe  <= ~rd_data[BYTE_W-1];
              state_q <= ST_TX;
            end else begin
              sda_oe    <= 1'b0;
              cmd_phase <= 1'b1;
              state_q   <= ST_RX;
            end
          end
        end
        ST_RX: begin
          if (scl_rise && !byte_in) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && byte_in) begin
            sda_oe    <= 1'b1;
            cmd_phase <= 1'b0;
            state_q   <= ST_RX_ACK;
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            state_q <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise && !byte_in) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall) begin
            if (byte_in) begin
              sda_oe  <= 1'b0;
              state_q <= ST_TX_ACK;
            end else begin
              tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx_sh[BYTE_W-2];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_sh   <= rd_data;
              sda_oe  <= ~rd_data[BYTE_W-1];
              bit_cnt <= '0;
              state_q <= ST_TX;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R12: the pull-down only engages while SCL is low
  p_oe_rise_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R2: a STOP always leaves SDA released
  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R3: nothing is driven while idle
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_oe);

  // R3: the address acknowledge holds SDA low
  p_addr_ack_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR_ACK) |-> sda_oe);

endmodule

// File: rtl/i2c_rb_regs.sv
`timescale 1ns/1ps
module i2c_rb_regs
  import i2c_rb_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int PTR_W    = 3,
  parameter int IN_W     = 2,
  parameter int AI_BIT   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_stb,
  input  logic                           wr_is_cmd,
  input  logic [BYTE_W-1:0]              wr_data,
  input  logic                           rd_stb,
  input  logic [IN_W-1:0]                port_in,
  output logic [BYTE_W-1:0]              rd_data,
  output logic [BYTE_W*(NUM_REGS-1)-1:0] reg_out
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_REGS - 1);

  logic [PTR_W-1:0]             ptr_q;
  logic                         ai_q;
  logic [PTR_W-1:0]             ptr_next;
  logic                         data_wr;
  logic [BYTE_W*NUM_REGS-1:0]   bank_flat;

  assign data_wr  = wr_stb && !wr_is_cmd;
  assign ptr_next = (ptr_q >= LAST_PTR) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      ai_q  <= 1'b0;
    end else if (wr_stb && wr_is_cmd) begin
      ptr_q <= wr_data[PTR_W-1:0];
      ai_q  <= wr_data[AI_BIT];
    end else if ((data_wr || rd_stb) && ai_q) begin
      ptr_q <= ptr_next;
    end
  end

  assign bank_flat[BYTE_W-1:0] = {{(BYTE_W-IN_W){1'b0}}, port_in};

  for (genvar k = 1; k < NUM_REGS; k++) begin : g_bank
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= reset_value(k, NUM_REGS);
      else if (data_wr && (ptr_q == PTR_W'(k))) q <= wr_data;
    end
    assign bank_flat[BYTE_W*k +: BYTE_W] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ptr_q == PTR_W'(i)) rd_data = bank_flat[BYTE_W*i +: BYTE_W];
    end
  end

  assign reg_out = bank_flat[BYTE_W*NUM_REGS-1:BYTE_W];

  // R7: a data write aimed at the input register leaves the bank untouched
  p_input_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ptr_q == '0) |=> $stable(reg_out));

  // R8: writes at unimplemented pointers leave the bank untouched
  p_unmapped_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ptr_q > LAST_PTR) |=> $stable(reg_out));

  // R4: the command byte never lands in the bank
  p_cmd_no_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_is_cmd) |=> $stable(reg_out));

  // R10: without auto-increment the pointer holds across data bytes
  p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_wr || rd_stb) && !ai_q) |=> $stable(ptr_q));

endmodule

// File: rtl/i2c_regbank_slave.sv
`timescale 1ns/1ps
module i2c_regbank_slave
  import i2c_rb_pkg::*;
#(
  parameter int         NUM_REGS    = 6,
  parameter int         PTR_W       = 3,
  parameter int         IN_W        = 2,
  parameter int         AI_BIT      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_FIXED  = 6'b110000
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           scl_in,
  input  logic                           sda_in,
  output logic                           sda_oe,
  input  logic                           addr_sel,
  input  logic [IN_W-1:0]                port_in,
  output logic [BYTE_W*(NUM_REGS-1)-1:0] reg_out
);

  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              wr_stb;
  logic              wr_is_cmd;
  logic [BYTE_W-1:0] wr_data;
  logic              rd_stb;
  logic [BYTE_W-1:0] rd_data;

  i2c_rb_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_rb_link #(.ADDR_FIXED(ADDR_FIXED)) link_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .addr_sel  (addr_sel),
    .rd_data   (rd_data),
    .wr_stb    (wr_stb),
    .wr_is_cmd (wr_is_cmd),
    .wr_data   (wr_data),
    .rd_stb    (rd_stb),
    .sda_oe    (sda_oe)
  );

  i2c_rb_regs #(
    .NUM_REGS (NUM_REGS),
    .PTR_W    (PTR_W),
    .IN_W     (IN_W),
    .AI_BIT   (AI_BIT)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_is_cmd (wr_is_cmd),
    .wr_data   (wr_data),
    .rd_stb    (rd_stb),
    .port_in   (port_in),
    .rd_data   (rd_data),
    .reg_out   (reg_out)
  );

endmodule

// File: tb/i2c_regbank_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_regbank_slave_tb_top;

  localparam int Q = 8;
  localparam int WATCHDOG = 190000;

  logic        clk;
  logic        rst_n;
  logic        scl_m;
  logic        sda_m;
  logic        sda_line;
  logic        sda_oe;
  logic        a0_pin;
  logic [1:0]  port_val;
  logic [39:0] reg_out;

  int n_checks = 0;
  int n_fail   = 0;
  int r12_viol = 0;

  logic [7:0] mdl [8];
  logic [2:0] mptr;
  logic       mai;

  assign sda_line = sda_m & ~sda_oe;

  i2c_regbank_slave dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_m),
    .sda_in   (sda_line),
    .sda_oe   (sda_oe),
    .addr_sel (a0_pin),
    .port_in  (port_val),
    .reg_out  (reg_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // R12 monitor: pull-down changes with SCL held high
  logic prev_oe;
  logic prev_scl;
  initial begin
    prev_oe = 1'b0;
    prev_scl = 1'b1;
  end
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && (sda_oe != prev_oe)) r12_viol++;
    prev_oe  <= sda_oe;
    prev_scl <= scl_m;
  end

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [2:0] mnext(input logic [2:0] p);
    return (p >= 3'd5) ? 3'd0 : p + 3'd1;
  endfunction

  function automatic logic [7:0] mread(input logic [2:0] p);
    if (p == 3'd0) return {6'b0, port_val};
    else if (p <= 3'd5) return mdl[p];
    else return 8'h00;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    mdl[2] = 8'h80;
    mdl[4] = 8'h80;
    mdl[5] = 8'hF0;
    mptr = 3'd0;
    mai  = 1'b0;
  endtask

  task automatic check_bank(input string tag);
    for (int k = 1; k <= 5; k++) check_eq(tag, 32'(reg_out[8*(k-1) +: 8]), 32'(mdl[k]));
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic more);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~more);
  endtask

  task automatic write_txn(input logic [6:0] dev, input logic [7:0] cmd, input int nbytes,
                           input logic [7:0] base, input logic exp_ack);
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte({dev, 1'b0}, a);
    check_eq("R3 write address ack", 32'(a), 32'(exp_ack));
    send_byte(cmd, a);
    check_eq("R4 command ack", 32'(a), 32'(exp_ack));
    if (exp_ack) begin
      mptr = cmd[2:0];
      mai  = cmd[4];
    end
    for (int j = 0; j < nbytes; j++) begin
      d = base + 8'(j * 37);
      send_byte(d, a);
      check_eq("R6 data ack", 32'(a), 32'(exp_ack));
      if (exp_ack) begin
        if (mptr >= 3'd1 && mptr <= 3'd5) mdl[mptr] = d;
        if (mai) mptr = mnext(mptr);
      end
    end
    bus_stop();
    tick(4);
    check_eq("R2 released after stop", 32'(sda_oe), 32'd0);
  endtask

  task automatic read_txn(input logic [6:0] dev, input logic [7:0] cmd, input int nbytes);
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte({dev, 1'b0}, a);
    check_eq("R3 address ack before read", 32'(a), 32'd1);
    send_byte(cmd, a);
    check_eq("R4 command ack before read", 32'(a), 32'd1);
    mptr = cmd[2:0];
    mai  = cmd[4];
    bus_start();
    send_byte({dev, 1'b1}, a);
    check_eq("R2 R3 read address ack after repeated start", 32'(a), 32'd1);
    for (int j = 0; j < nbytes; j++) begin
      recv_byte(d, j != nbytes - 1);
      check_eq("R11 R9 read byte", 32'(d), 32'(mread(mptr)));
      if (mai) mptr = mnext(mptr);
    end
    tick(2);
    check_eq("R11 released after NACK", 32'(sda_oe), 32'd0);
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic a;
    logic [7:0] d;
    logic [6:0] dev0;
    dev0 = 7'b1100000;
    rst_n = 1'b0;
    scl_m = 1'b1;
    sda_m = 1'b1;
    a0_pin = 1'b0;
    port_val = 2'b10;
    model_reset();
    tick(10);
    // R1 reset state, also R5 mapping
    check_bank("R1 R5 reset defaults");
    check_eq("R1 sda released in reset", 32'(sda_oe), 32'd0);
    rst_n = 1'b1;
    tick(10);
    check_bank("R1 defaults after release");

    // R6 R7 R8 R9: write sweep over every start pointer with auto-increment
    for (int s = 0; s < 8; s++) begin
      write_txn(dev0, 8'h10 | 8'(s), 3, 8'(8'h11 * (s + 1)), 1'b1);
      check_bank("R6 R7 R8 R9 bank after auto-increment write");
    end

    // R9 R11 R7 R8: read sweep over every start pointer, wrap included
    for (int s = 0; s < 8; s++) begin
      port_val = 2'(s);
      read_txn(dev0, 8'h10 | 8'(s), 4);
    end

    // R10: fixed pointer for writes and reads
    write_txn(dev0, 8'h02, 3, 8'h4D, 1'b1);
    check_bank("R10 only last byte stays at fixed pointer");
    check_eq("R10 duty0 holds last byte", 32'(reg_out[15:8]), 32'(8'(8'h4D + 8'd74)));
    read_txn(dev0, 8'h03, 3);

    // R4: unused command bits ignored (pointer 1, auto-increment clear)
    write_txn(dev0, 8'hE9, 2, 8'h5A, 1'b1);
    check_bank("R4 unused command bits ignored");

    // R3: address strap
    a0_pin = 1'b1;
    write_txn(dev0, 8'h05, 2, 8'h77, 1'b0);
    check_bank("R3 mismatched address changes nothing");
    write_txn(dev0 | 7'd1, 8'h05, 1, 8'h3C, 1'b1);
    check_bank("R3 strapped address accepted");
    check_eq("R3 selector written", 32'(reg_out[39:32]), 32'h3C);
    a0_pin = 1'b0;

    // R13: reset halfway through a data byte
    bus_start();
    send_byte({dev0, 1'b0}, a);
    send_byte(8'h11, a);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    rst_n = 1'b0;
    tick(4);
    model_reset();
    check_bank("R13 reset mid-transfer restores bank");
    check_eq("R13 sda released by reset", 32'(sda_oe), 32'd0);
    rst_n = 1'b1;
    tick(4);
    bus_stop();
    // R1: pointer reset to 0, read without command byte returns the input port
    port_val = 2'b01;
    bus_start();
    send_byte({dev0, 1'b1}, a);
    check_eq("R1 read address ack", 32'(a), 32'd1);
    recv_byte(d, 1'b0);
    check_eq("R1 R7 pointer resets to input register", 32'(d), 32'h01);
    bus_stop();
    tick(4);
    check_bank("R13 bank still at defaults");

    check_eq("R12 sda_oe stable while SCL high", 32'(r12_viol), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule